// File: doc/BRIEF.md
# Periodic Whole-Packet Discard Stage

This stage sits inline on a packet stream of 64-bit data words, each paired with an 8-bit control word. It forwards traffic unchanged. When it is enabled, it removes one complete packet out of every N. It finds packet boundaries from the control word alone. A packet starts with one or more header words, whose control word is non-zero. Payload words follow with a control word of zero. The packet ends at the first word with a non-zero control word that follows a zero-control word.

Two plain configuration pins control the stage: an enable bit and the spacing N. The block also exposes a 16-bit packet count. Each counted packet start pulses the count up by one. When the count would reach N, a clear pulse returns it to zero instead, and that packet is discarded.

Both sides use a valid/ready handshake, and a word moves when valid and ready are both high in the same cycle. Forwarded words pass through with no added latency. While a word is being forwarded, upstream ready follows downstream ready, so back-pressure reaches the source directly. While a word is being discarded, upstream ready is held high and downstream valid stays low, so a dropped packet drains at one word per cycle whatever the state of downstream ready. The discard decision is taken at a packet's first word and holds for the rest of that packet.

Top module: `pktdrop_nth`

## Requirements
- R1: A word accepted while no packet is open starts a packet. A word with control value 0 is a payload word. The first accepted word with a non-zero control value after a payload word ends the packet. Non-zero header words (for example 0xFF) before the first payload word do not end it. A minimum packet is therefore header, payload, last (for example 0x10).
- R2: With `cfg_enable` at 0, every word is forwarded and `pkt_count` holds its value.
- R3: With `cfg_period` at 0, every word is forwarded and `pkt_count` holds its value, whatever `cfg_enable` is.
- R4: With `cfg_enable` at 1 and `cfg_period` N > 0, each accepted first word raises `pkt_count` by one. When count+1 would reach N, that packet is discarded and `pkt_count` returns to 0 instead. With N=3, packets 3, 6, 9, … are discarded.
- R5: Every word of a discarded packet is accepted with `in_ready` high, regardless of `out_ready`, and `out_valid` stays low for all of its words.
- R6: A forwarded word appears on `out_valid`/`out_data`/`out_ctrl` in the same cycle as on the input, unchanged. `in_ready` equals `out_ready` for it.
- R7: `cfg_enable` and `cfg_period` are sampled only at a packet's first word. Changes made inside a packet apply from the next packet.
- R8: If N is lowered so that count+1 ≥ N, the next packet is discarded and the count returns to 0.
- R9: After reset, `pkt_count` is 0 and the next accepted word starts a packet.
- R10: N=1 discards every packet, and `pkt_count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | 1 enables periodic discard |
| cfg_period | input | 16 | Spacing N; 0 disables discard |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Stage accepts upstream word |
| in_data | input | 64 | Upstream data word |
| in_ctrl | input | 8 | Upstream control word |
| out_valid | output | 1 | Downstream word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | 64 | Downstream data word |
| out_ctrl | output | 8 | Downstream control word |
| pkt_count | output | 16 | Current packet count |

## Verification
The bench uses the default widths: 64-bit data, 8-bit control and a 16-bit counter. Spacings of 0, 1, 2, 3, 4, 5 and 100 bring every case within reach in a few dozen packets. These cases are the first-packet discard, a discard on every packet, a steady one-in-three pattern, a lowered N that forces an immediate discard, and a large N that never triggers. Pseudo-random downstream stalls and input gaps exercise the rule that a discarded packet ignores `out_ready`.

// File: rtl/pktdrop_pkg.sv
package pktdrop_pkg;
  typedef enum logic [1:0] {
    FR_START = 2'd0,
    FR_HDR   = 2'd1,
    FR_BODY  = 2'd2
  } fr_state_e;
endpackage

// File: rtl/pktdrop_framer.sv
module pktdrop_framer
  import pktdrop_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              sop,
  output logic              eop
);
  fr_state_e st_q, st_d;
  logic      ctrl_nz;

  assign ctrl_nz = |ctrl;
  assign sop     = (st_q == FR_START);
  assign eop     = (st_q == FR_BODY) && ctrl_nz;

  always_comb begin
    st_d = st_q;
    if (beat) begin
      unique case (st_q)
        FR_START: st_d = ctrl_nz ? FR_HDR : FR_BODY;
        FR_HDR:   st_d = ctrl_nz ? FR_HDR : FR_BODY;
        FR_BODY:  st_d = ctrl_nz ? FR_START : FR_BODY;
        default:  st_d = FR_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= FR_START;
    else        st_q <= st_d;
  end

  AST_EOP_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && eop) |=> sop) else $error("end of packet did not rearm"); // R1

  AST_HDR_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sop) |=> !sop) else $error("packet start did not open packet"); // R1
endmodule

// File: rtl/pktdrop_pacer.sv
module pktdrop_pacer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop_beat,
  input  logic             cfg_enable,
  input  logic [CNT_W-1:0] cfg_period,
  output logic             drop_dec,
  output logic [CNT_W-1:0] count
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] next_ext;
  logic             active, hit, inc_pulse, clr_pulse;
  logic [CNT_W-1:0] cnt_q;

  assign active    = cfg_enable && (cfg_period != '0);
  assign next_ext  = {1'b0, cnt_q} + EXT_W'(1);
  assign hit       = next_ext >= {1'b0, cfg_period};
  assign drop_dec  = active && hit;
  assign inc_pulse = sop_beat && active && !hit;
  assign clr_pulse = sop_beat && active && hit;
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr_pulse) cnt_q <= '0;
    else if (inc_pulse) cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cnt_q == '0)) else $error("clear pulse left count"); // R4

  AST_INC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pulse |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("bad step"); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sop_beat || !active) |=> $stable(cnt_q)) else $error("count moved"); // R2
endmodule

// File: rtl/pktdrop_gate.sv
module pktdrop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sop,
  input  logic beat,
  input  logic drop_dec,
  input  logic in_valid,
  input  logic out_ready,
  output logic drop_cur,
  output logic out_valid,
  output logic in_ready
);
  logic drop_q;

  assign drop_cur  = sop ? drop_dec : drop_q;
  assign out_valid = in_valid && !drop_cur;
  assign in_ready  = drop_cur || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)           drop_q <= 1'b0;
    else if (beat && sop) drop_q <= drop_dec;
  end

  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(beat && sop)) |=> $stable(drop_q)) else $error("decision changed mid packet"); // R7
endmodule

// File: rtl/pktdrop_nth.sv
module pktdrop_nth #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic [CNT_W-1:0]  pkt_count
);
  logic beat, sop, eop, drop_dec, drop_cur;

  assign beat     = in_valid && in_ready;
  assign out_data = in_data;
  assign out_ctrl = in_ctrl;

  pktdrop_framer #(.CTRL_W(CTRL_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .beat(beat), .ctrl(in_ctrl),
    .sop(sop), .eop(eop)
  );

  pktdrop_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .sop_beat(beat && sop),
    .cfg_enable(cfg_enable), .cfg_period(cfg_period),
    .drop_dec(drop_dec), .count(pkt_count)
  );

  pktdrop_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sop(sop), .beat(beat), .drop_dec(drop_dec),
    .in_valid(in_valid), .out_ready(out_ready),
    .drop_cur(drop_cur), .out_valid(out_valid), .in_ready(in_ready)
  );

  AST_DROP_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_valid) |-> in_ready) else $error("dropped word stalled"); // R5

  AST_FWD_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready == out_ready)) else $error("back-pressure broken"); // R6

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sop && !cfg_enable) |-> out_valid) else $error("disabled drop"); // R2

  AST_ZERO_N_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sop && cfg_period == '0) |-> out_valid) else $error("N=0 drop"); // R3

  AST_EOP_ACCEPTED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && eop) |=> !eop) else $error("double end"); // R1
endmodule

// File: tb/pktdrop_nth_tb_top.sv
`timescale 1ns/1ps
module pktdrop_nth_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [15:0] cfg_period = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic [15:0] pkt_count;

  int n_checks = 0;
  int n_fail   = 0;
  int fwd_pkts = 0;
  int pkt_id   = 0;
  string cur_req = "R9";
  logic bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_st = 0;       // 0 idle, 1 header, 2 payload
  int m_cnt = 0;
  bit m_drop = 0;
  int n_st; int n_cnt; bit n_drop;

  always #2 clk = ~clk;

  pktdrop_nth dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_period(cfg_period),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ctrl(out_ctrl), .pkt_count(pkt_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle reference compare
  always @(negedge clk) begin
    if (rst_n) begin
      bit sop, active, hit, dcur, e_ov, e_ir, bt;
      sop    = (m_st == 0);
      active = cfg_enable && (cfg_period != 0);
      hit    = (m_cnt + 1) >= int'(cfg_period);
      dcur   = sop ? (active && hit) : m_drop;
      e_ov   = in_valid && !dcur;
      e_ir   = dcur || out_ready;
      chk(out_valid == e_ov, cur_req, "out_valid", out_valid, e_ov);
      chk(in_ready == e_ir, cur_req, "in_ready", in_ready, e_ir);
      chk(int'(pkt_count) == m_cnt, cur_req, "pkt_count", pkt_count, m_cnt);
      if (e_ov) chk(out_data == in_data && out_ctrl == in_ctrl, "R6", "data",
                    out_data, in_data);
      bt = in_valid && e_ir;
      n_st = m_st; n_cnt = m_cnt; n_drop = m_drop;
      if (bt) begin
        if (sop) begin
          n_drop = active && hit;
          if (active) n_cnt = hit ? 0 : m_cnt + 1;
        end
        case (m_st)
          0, 1: n_st = (in_ctrl != 0) ? 1 : 2;
          default: n_st = (in_ctrl != 0) ? 0 : 2;
        endcase
      end
      if (out_valid && out_ready && out_ctrl == 8'h10) fwd_pkts++;
    end else begin
      n_st = 0; n_cnt = 0; n_drop = 0;
    end
  end

  always @(posedge clk) begin
    m_st <= n_st; m_cnt <= n_cnt; m_drop <= n_drop;
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  task automatic send_pkt(input int n_hdr, input int n_body, input int gap,
                          input int mid_per, input int mid_en);
    int total;
    total = n_hdr + n_body + 1;
    pkt_id++;
    for (int w = 0; w < total; w++) begin
      bit took;
      in_valid = 1'b1;
      in_data  = {32'(pkt_id), 32'(w)};
      in_ctrl  = (w < n_hdr) ? 8'hFF : ((w == total - 1) ? 8'h10 : 8'h00);
      do begin
        @(negedge clk); took = in_ready;
        @(posedge clk); #1;
      end while (!took);
      if (w == 1 && mid_per >= 0) cfg_period = 16'(mid_per);
      if (w == 1 && mid_en >= 0)  cfg_enable = mid_en[0];
      if (gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
    in_ctrl  = '0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired in phase %s actual=0 expected=1", cur_req);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(pkt_count == 0, "R9", "count after reset", pkt_count, 0);
    chk(out_valid == 0, "R9", "out_valid after reset", out_valid, 0);
    @(posedge clk); #1;

    // R2: disabled passes all
    cur_req = "R2"; cfg_enable = 0; cfg_period = 3; fwd_pkts = 0;
    for (int i = 0; i < 5; i++) send_pkt(1, 2, 0, -1, -1);
    settle();
    chk(fwd_pkts == 5, "R2", "forwarded packets", fwd_pkts, 5);
    chk(pkt_count == 0, "R2", "count held", pkt_count, 0);

    // R3: N=0 passes all
    cur_req = "R3"; cfg_enable = 1; cfg_period = 0; fwd_pkts = 0;
    for (int i = 0; i < 4; i++) send_pkt(1, 3, 1, -1, -1);
    settle();
    chk(fwd_pkts == 4, "R3", "forwarded packets", fwd_pkts, 4);
    chk(pkt_count == 0, "R3", "count held", pkt_count, 0);

    // R4/R5/R6: N=3 under back-pressure
    cur_req = "R4"; cfg_period = 3; bp_on = 1; fwd_pkts = 0;
    for (int i = 0; i < 9; i++) send_pkt(1, 4, 0, -1, -1);
    settle();
    chk(fwd_pkts == 6, "R4", "one in three dropped", fwd_pkts, 6);
    chk(pkt_count == 0, "R5", "count after 9", pkt_count, 0);
    bp_on = 0;

    // R10: N=1 drops everything
    cur_req = "R10"; cfg_period = 1; fwd_pkts = 0;
    for (int i = 0; i < 4; i++) send_pkt(2, 2, 0, -1, -1);
    settle();
    chk(fwd_pkts == 0, "R10", "all dropped", fwd_pkts, 0);
    chk(pkt_count == 0, "R10", "count stays 0", pkt_count, 0);

    // R8: lowering N below count
    cur_req = "R8"; cfg_period = 4; fwd_pkts = 0;
    send_pkt(1, 1, 0, -1, -1);
    send_pkt(1, 1, 0, -1, -1);
    settle();
    chk(pkt_count == 2, "R8", "count before lowering", pkt_count, 2);
    cfg_period = 2;
    send_pkt(1, 1, 0, -1, -1);
    settle();
    chk(fwd_pkts == 2, "R8", "lowered N drops next", fwd_pkts, 2);
    chk(pkt_count == 0, "R8", "count cleared", pkt_count, 0);
    send_pkt(1, 1, 0, -1, -1);
    settle();

    // R7: mid-packet configuration changes
    cur_req = "R7"; fwd_pkts = 0;
    send_pkt(1, 3, 0, 100, -1);   // count 1 -> hit N=2, dropped despite change
    settle();
    chk(fwd_pkts == 0, "R7", "packet kept its drop decision", fwd_pkts, 0);
    send_pkt(1, 3, 0, -1, 0);     // N=100, count 0->1, disable mid packet
    settle();
    chk(pkt_count == 1, "R7", "count moved with start-time enable", pkt_count, 1);
    send_pkt(1, 2, 0, -1, -1);    // disabled now
    settle();
    chk(fwd_pkts == 2, "R7", "forwarded after changes", fwd_pkts, 2);
    chk(pkt_count == 1, "R7", "disabled holds count", pkt_count, 1);

    // R1: framing with several header words and gaps
    cur_req = "R1"; cfg_enable = 1; cfg_period = 5; fwd_pkts = 0;
    send_pkt(3, 2, 2, -1, -1);
    settle();
    chk(pkt_count == 2, "R1", "multi-header counted once", pkt_count, 2);
    send_pkt(1, 1, 1, -1, -1);
    settle();
    chk(pkt_count == 3, "R1", "minimum packet counted", pkt_count, 3);
    chk(fwd_pkts == 2, "R1", "both forwarded", fwd_pkts, 2);

    finish_run();
  end
endmodule